// File: doc/BRIEF.md
# Receive Input Sampling Timing Adjuster

This block captures a receive-enable line and four receive data bits against a slow receive clock. It does not use the receive clock as a clock. It runs entirely on a faster timing-adjust clock and treats the receive clock as an ordinary input. A two-flop synchronizer and an edge comparator find every rising and every falling receive clock transition. A counter restarts at each transition. Each of the five lanes is captured once per half-period, in the cycle where the counter equals that lane's target.

The lane target comes from one of three sources:
- **Programmed delay:** a 5-bit field sets the target.
- **Automatic point:** the target is half the length of the previous half-period.
- **Bypass:** when the adjuster is disabled, every lane is captured at the first count.

A 5-bit skew mask gives any lane one extra timing-adjust cycle of delay. This compensates lanes whose traces arrive late.

After all five lanes of a half-period are captured, a one-cycle strobe marks the new sample. If the next receive clock transition arrives before every lane has been captured, that half-period produces no strobe and a sticky overrun flag is set.

Top module: `rx_sample_adjuster`

## Requirements
- R1: With `cfg_enable` low, all five lanes are captured at the 4th rising edge of `adj_clk` after a receive clock transition. `cfg_delay`, `cfg_skew` and `cfg_auto` have no effect on when capture happens.
- R2: Both rising and falling receive clock transitions restart the counter, so every half-period produces its own sample.
- R3: With `cfg_enable` high and `cfg_auto` low, a lane whose skew bit is clear is captured at rising edge number `cfg_delay`+4 of `adj_clk` after the transition. This holds for the full range 0..31. A lane's output changes only when that lane captures.
- R4: The skew mask bits map to lanes as follows: bit 0 is the receive-enable, bit 1 is data bit 3, bit 2 is data bit 2, bit 3 is data bit 1, and bit 4 is data bit 0.
- R5: A set skew bit delays that lane's capture by exactly one `adj_clk` cycle.
- R6: With `cfg_enable` and `cfg_auto` high, `cfg_delay` is ignored. The base capture count is floor(L/2), where L is the previous half-period length in `adj_clk` cycles. Skew still adds one cycle on top of this base.
- R7: If a transition arrives while any lane of the current half-period is still uncaptured, that half-period gives no strobe and `overrun` goes high. `overrun` then stays high until reset. It never rises while every lane captures in time.
- R8: `smp_valid` is high for exactly one `adj_clk` cycle per half-period, in the cycle when the five captured values appear together.
- R9: During reset, all sampled outputs, `smp_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adj_clk | input | 1 | Timing-adjust clock; every register uses it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_clk_in | input | 1 | Receive clock, sampled as data |
| rx_en_in | input | 1 | Raw receive-enable |
| rx_d_in | input | 4 | Raw receive data |
| cfg_enable | input | 1 | 1 = adjust logic active, 0 = bypass |
| cfg_auto | input | 1 | 1 = automatic capture point |
| cfg_delay | input | 5 | Programmed capture count |
| cfg_skew | input | 5 | Per-lane one-cycle skew mask |
| smp_en | output | 1 | Captured receive-enable |
| smp_d | output | 4 | Captured receive data |
| smp_valid | output | 1 | One-cycle strobe for a new half-period sample |
| overrun | output | 1 | Sticky flag: a capture was missed |

## Verification
The bench drives each lane high for a single `adj_clk` cycle: exactly the cycle before that lane's predicted capture edge. A one-cycle error in synchronizer latency, delay, skew or automatic point therefore captures 0 where 1 is expected. Changing per-half masks make a swapped skew bit order, or a lane that never recaptures, show up as a wrong bit.

Each test counts strobes over a fixed number of half-periods. A design that restarts on only one edge, or that strobes twice, gives the wrong count.

Further cases cover:
- delay 0 and delay 31;
- bypass with every skew bit set;
- an automatic point following a change of receive clock period;
- a delay longer than the half-period, where the design must stay silent and set the sticky overrun.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int LANES = 5;
  typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/rxa_rst_sync.sv
module rxa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rxa_edge_timer.sv
module rxa_edge_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_clk_in,
  output logic             edge_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] auto_pt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pt_q, pt_d;
  logic [CNT_W:0]   len_ext;
  logic             edge_hit;

  // two synchronizer flops, third flop holds the previous level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= {sync_q[1:0], rx_clk_in};
  end

  assign edge_hit = sync_q[1] ^ sync_q[2];
  assign len_ext  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    cnt_d = cnt_q;
    pt_d  = pt_q;
    if (edge_hit) begin
      cnt_d = '0;
      pt_d  = len_ext[CNT_W:1];
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      pt_q  <= pt_d;
    end
  end

  assign edge_o    = edge_hit;
  assign cnt_o     = cnt_q;
  assign auto_pt_o = pt_q;

  p_cnt_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (cnt_q == '0));
  p_cnt_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_hit && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/rxa_lane.sv
module rxa_lane #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             din_i,
  output logic             dout_o,
  output logic             pend_o,
  output logic             hit_o
);
  logic pend_q, pend_d;
  logic data_q, data_d;
  logic hit;

  assign hit = pend_q && !start_i && (cnt_i == target_i);

  always_comb begin
    pend_d = pend_q;
    data_d = data_q;
    if (start_i)  pend_d = 1'b1;
    else if (hit) pend_d = 1'b0;
    if (hit)      data_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      data_q <= data_d;
    end
  end

  assign dout_o = data_q;
  assign pend_o = pend_q;
  assign hit_o  = hit;

  p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(dout_o));
  p_lane_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (dout_o == $past(din_i)));
endmodule

// File: rtl/rx_sample_adjuster.sv
module rx_sample_adjuster #(
  parameter int DLY_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             adj_clk,
  input  logic             rst_n,
  input  logic             rx_clk_in,
  input  logic             rx_en_in,
  input  logic [3:0]       rx_d_in,
  input  logic             cfg_enable,
  input  logic             cfg_auto,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [4:0]       cfg_skew,
  output logic             smp_en,
  output logic [3:0]       smp_d,
  output logic             smp_valid,
  output logic             overrun
);
  import rxa_pkg::*;

  logic             rst_s_n;
  logic             edge_hit;
  logic [CNT_W-1:0] cnt, auto_pt, base_pt;
  lane_vec_t        raw, cap, pend, hit;
  logic             valid_q, valid_d, ovr_q, ovr_d, all_done;

  rxa_rst_sync u_rst (.clk(adj_clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  rxa_edge_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(adj_clk), .rst_n(rst_s_n), .rx_clk_in(rx_clk_in),
    .edge_o(edge_hit), .cnt_o(cnt), .auto_pt_o(auto_pt)
  );

  // lane order: enable, then data from bit 3 down to bit 0
  assign raw = {rx_d_in[0], rx_d_in[1], rx_d_in[2], rx_d_in[3], rx_en_in};

  always_comb begin
    if (!cfg_enable)   base_pt = '0;
    else if (cfg_auto) base_pt = auto_pt;
    else               base_pt = CNT_W'(cfg_delay);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CNT_W-1:0] tgt;
    assign tgt = base_pt + CNT_W'(cfg_enable & cfg_skew[i]);
    rxa_lane #(.CNT_W(CNT_W)) u_lane (
      .clk(adj_clk), .rst_n(rst_s_n), .start_i(edge_hit), .cnt_i(cnt),
      .target_i(tgt), .din_i(raw[i]), .dout_o(cap[i]), .pend_o(pend[i]),
      .hit_o(hit[i])
    );
  end

  assign all_done = (pend != '0) && ((pend & ~hit) == '0) && !edge_hit;

  always_comb begin
    valid_d = all_done;
    ovr_d   = ovr_q | (edge_hit && (pend != '0));
  end

  always_ff @(posedge adj_clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  assign smp_en    = cap[0];
  assign smp_d     = {cap[1], cap[2], cap[3], cap[4]};
  assign smp_valid = valid_q;
  assign overrun   = ovr_q;

  p_valid_pulse_r8: assert property (@(posedge adj_clk) disable iff (!rst_s_n)
    smp_valid |=> !smp_valid);
  p_valid_all_taken_r8: assert property (@(posedge adj_clk) disable iff (!rst_s_n)
    smp_valid |-> (pend == '0));
  p_overrun_sticky_r7: assert property (@(posedge adj_clk) disable iff (!rst_s_n)
    overrun |=> overrun);
  p_overrun_no_strobe_r7: assert property (@(posedge adj_clk) disable iff (!rst_s_n)
    $rose(overrun) |-> !smp_valid);
endmodule

// File: tb/sim_rx_sample_adjuster.sv
module sim_rx_sample_adjuster;
  logic       adj_clk = 1'b0;
  logic       rst_n, rx_clk_in, rx_en_in;
  logic [3:0] rx_d_in;
  logic       cfg_enable, cfg_auto;
  logic [4:0] cfg_delay, cfg_skew;
  logic       smp_en, smp_valid, overrun;
  logic [3:0] smp_d;

  int n_chk = 0, n_fail = 0;
  int hp = 16, ph = 0, n_toggle = 0, n_valid = 0;
  int win [5];
  bit run = 0, chk_on = 0, done = 0;
  string cur_req = "R3";

  always #2 adj_clk = ~adj_clk;

  rx_sample_adjuster u0 (
    .adj_clk(adj_clk), .rst_n(rst_n), .rx_clk_in(rx_clk_in), .rx_en_in(rx_en_in),
    .rx_d_in(rx_d_in), .cfg_enable(cfg_enable), .cfg_auto(cfg_auto),
    .cfg_delay(cfg_delay), .cfg_skew(cfg_skew), .smp_en(smp_en), .smp_d(smp_d),
    .smp_valid(smp_valid), .overrun(overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] mask_of(int t);
    return 5'((t * 11 + 5) & 31);
  endfunction

  // lane vector: bit0 enable, bit1 d3, bit2 d2, bit3 d1, bit4 d0
  always @(negedge adj_clk) begin
    if (run) begin
      if (chk_on && smp_valid) begin
        n_valid++;
        chk({cur_req, " sample"}, {27'd0, smp_d[0], smp_d[1], smp_d[2], smp_d[3], smp_en},
            {27'd0, mask_of(n_toggle)});
      end
      ph++;
      if (ph >= hp) begin
        ph = 0;
        rx_clk_in = ~rx_clk_in;
        n_toggle++;
      end
      begin
        logic [4:0] m, v;
        m = mask_of(n_toggle);
        for (int i = 0; i < 5; i++) v[i] = m[i] && (ph == win[i]);
        rx_en_in = v[0];
        rx_d_in  = {v[1], v[2], v[3], v[4]};
      end
    end
  end

  task automatic wait_toggles(int k);
    int tgt;
    tgt = n_toggle + k;
    while (n_toggle < tgt) @(posedge adj_clk);
    #1;
  endtask

  task automatic run_cfg(string req, bit en, bit au, int dly, logic [4:0] sk,
                         int hpv, int halves);
    cfg_enable = en; cfg_auto = au; cfg_delay = 5'(dly); cfg_skew = sk;
    hp = hpv; cur_req = req; chk_on = 0;
    for (int i = 0; i < 5; i++)
      win[i] = !en ? 3 : ((au ? 3 + hpv / 2 : 3 + dly) + int'(sk[i]));
    wait_toggles(2);
    n_valid = 0; chk_on = 1;
    wait_toggles(halves);
    chk({req, " one strobe per half (R2 R8)"}, n_valid, halves);
    chk_on = 0;
  endtask

  task automatic t_reset_state;
    rst_n = 0;
    repeat (3) @(posedge adj_clk);
    #1;
    chk("R9 reset outputs", {28'd0, smp_valid, overrun, smp_en, smp_d != 4'd0}, 0);
    rst_n = 1;
    repeat (3) @(posedge adj_clk);
    #1;
  endtask

  task automatic t_delay;
    run_cfg("R3", 1, 0, 5, 5'b00000, 16, 6);
    run_cfg("R3", 1, 0, 0, 5'b00000, 16, 6);
    run_cfg("R3", 1, 0, 31, 5'b00000, 40, 4);
  endtask

  task automatic t_skew;
    run_cfg("R5", 1, 0, 2, 5'b00001, 16, 6);
    run_cfg("R4", 1, 0, 4, 5'b10100, 16, 6);
    run_cfg("R4", 1, 0, 3, 5'b01010, 16, 6);
    run_cfg("R5", 1, 0, 30, 5'b11111, 40, 4);
  endtask

  task automatic t_auto;
    run_cfg("R6", 1, 1, 1, 5'b00000, 16, 6);
    run_cfg("R6", 1, 1, 20, 5'b00011, 24, 6);
  endtask

  task automatic t_bypass;
    run_cfg("R1", 0, 1, 9, 5'b11111, 16, 6);
  endtask

  task automatic t_overrun;
    t_reset_state();
    run_cfg("R7", 1, 0, 3, 5'b00000, 16, 3);
    chk("R7 no false overrun", overrun, 0);
    cfg_delay = 5'd31; cur_req = "R7";
    wait_toggles(1);
    n_valid = 0; chk_on = 1;
    wait_toggles(3);
    chk("R7 no strobe when skipped", n_valid, 0);
    chk("R7 overrun set", overrun, 1);
    chk_on = 0;
    cfg_delay = 5'd3;
    wait_toggles(3);
    chk("R7 overrun sticky", overrun, 1);
  endtask

  initial begin
    rx_clk_in = 0; rx_en_in = 0; rx_d_in = 0;
    cfg_enable = 1; cfg_auto = 0; cfg_delay = 0; cfg_skew = 0;
    for (int i = 0; i < 5; i++) win[i] = 3;
    t_reset_state();
    run = 1;
    t_delay();
    t_skew();
    t_auto();
    t_bypass();
    t_overrun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule